// File: doc/BRIEF.md
# Interrupt Pending Priority Presenter

This block is the presentation context of one processor. It records pending interrupt notifications in an 8-bit bitmap with one bit for each priority level. From that bitmap it derives the most favored pending priority and compares it with a current processor priority that software writes. A lower number is a more favored priority. When the pending priority is more favored than the current priority, the block raises the processor's interrupt line and sets an exception-outstanding flag in its status byte.

The processor answers with an acknowledge strobe, which takes one cycle. In that cycle the block returns the pending priority and lifts the current priority to that level. In the next cycle the served bit is gone from the bitmap, and the flag and the interrupt line are clear. Notifications reach the block already routed, so the block receives only a priority. All state is visible on output ports.

Top module: `prio_presenter`

## Requirements
- R1: After reset, the pending bitmap is 0, the pending priority is 0xFF, the current priority is 0, the status byte is 0 and irq is low.
- R2: An accepted notification with priority p from 0 to 7 sets bit (7 - p) of the pending bitmap one cycle later, so priority 0 sets bit 7. Bits that are already set stay set until an acknowledge clears them.
- R3: A notification with priority 8 to 0xFE adds no bit to the bitmap, although it still runs the compare. A notification with priority 0xFF is discarded: it adds no bit and runs no compare.
- R4: pend_prio always equals the count of leading zeros of the pending bitmap, which is the number of the most favored pending priority. It reads 0xFF when the bitmap is 0.
- R5: A write of the current priority with a value above 7 is rejected and leaves cur_prio unchanged. A write of 0 to 7 is loaded one cycle later.
- R6: If the compare finds the pending priority strictly less than the current priority, irq and status bit 7 (exception outstanding) are 1 from the next cycle on. Both stay set until an acknowledge. Status bits 6 to 0 always read 0.
- R7: The compare runs in every cycle with an accepted notification or an accepted write of the current priority. It uses the values both registers hold after that cycle's updates, including a notification and a write that arrive in the same cycle.
- R8: While ack is high, ack_prio equals pend_prio in the same cycle. One cycle later:
  - cur_prio holds that value and the matching bit of the bitmap is cleared;
  - irq and status bit 7 are 0, unless a notification in the same cycle is more favored than the new cur_prio, in which case both are 1;
  - any write of the current priority made during the acknowledge has had no effect.

Two consequences of R8 follow. An acknowledge when the bitmap is 0 loads 0xFF into cur_prio. After that, a later write of 0 to 7 is still accepted, because only values above 7 are rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| note_valid | input | 1 | Notification strobe |
| note_prio | input | 8 | Priority of the notification |
| cur_wr | input | 1 | Write strobe for the current priority |
| cur_wdata | input | 8 | Current priority value to write |
| ack | input | 1 | Acknowledge strobe |
| ack_prio | output | 8 | Priority returned by the acknowledge |
| irq | output | 1 | Interrupt line to the processor |
| pend_buf | output | 8 | Pending bitmap (bit 7 is priority 0) |
| pend_prio | output | 8 | Most favored pending priority, 0xFF when none is pending |
| cur_prio | output | 8 | Current processor priority |
| status | output | 8 | Status byte (bit 7 is exception outstanding) |

## Verification
The assertions check the following on every cycle:
- the reset state;
- the leading-zero relation between the bitmap and pend_prio;
- that irq and the status flag always agree;
- that bitmap bits stay set without an acknowledge;
- that rejected writes leave cur_prio unchanged;
- that an acknowledge with no notification drops the line.

The assertions cannot show that the line rises exactly when the compare on the updated values says it should. They also cannot show which bit an acknowledge clears, or what happens when a notification and a write of the current priority arrive together. The bench scenarios show these, by comparing the outputs against a cycle model.

// File: rtl/prio_presenter.sv
module prio_presenter #(
  parameter int PW = 8,
  parameter int MAX_PRIO = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          note_valid,
  input  logic [PW-1:0] note_prio,
  input  logic          cur_wr,
  input  logic [PW-1:0] cur_wdata,
  input  logic          ack,
  output logic [PW-1:0] ack_prio,
  output logic          irq,
  output logic [PW-1:0] pend_buf,
  output logic [PW-1:0] pend_prio,
  output logic [PW-1:0] cur_prio,
  output logic [PW-1:0] status
);
  localparam int NLVL = MAX_PRIO + 1;
  localparam logic [PW-1:0] NONE = '1;

  logic [NLVL-1:0] buf_q, buf_base, buf_n, note_bit, ack_bit;
  logic [PW-1:0]   cur_q, cur_n, prio_n;
  logic            eo_q, note_ok, wr_ok, hit;

  function automatic logic [PW-1:0] lead_zeros(input logic [NLVL-1:0] b);
    lead_zeros = NONE;
    for (int i = 0; i < NLVL; i++)
      if (b[i]) lead_zeros = PW'(NLVL - 1 - i);
  endfunction

  assign pend_prio = lead_zeros(buf_q);
  assign ack_prio  = pend_prio;

  assign note_ok = note_valid && note_prio != NONE;
  assign wr_ok   = cur_wr && !ack && cur_wdata <= PW'(MAX_PRIO);

  always_comb begin
    note_bit = '0;
    ack_bit  = '0;
    for (int i = 0; i < NLVL; i++) begin
      if (note_ok && note_prio == PW'(NLVL - 1 - i)) note_bit[i] = 1'b1;
      if (ack && pend_prio == PW'(NLVL - 1 - i)) ack_bit[i] = 1'b1;
    end
  end

  assign buf_base = buf_q & ~ack_bit;
  assign buf_n    = buf_base | note_bit;
  assign prio_n   = lead_zeros(buf_n);
  assign cur_n    = ack ? pend_prio : (wr_ok ? cur_wdata : cur_q);
  assign hit      = (note_ok || wr_ok) && prio_n < cur_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q <= '0;
      cur_q <= '0;
      eo_q  <= 1'b0;
    end else begin
      buf_q <= buf_n;
      cur_q <= cur_n;
      if (hit)      eo_q <= 1'b1;
      else if (ack) eo_q <= 1'b0;
    end
  end

  assign irq      = eo_q;
  assign pend_buf = PW'(buf_q);
  assign cur_prio = cur_q;
  assign status   = {eo_q, {(PW-1){1'b0}}};
endmodule

// File: rtl/prio_presenter_chk.sv
module prio_presenter_chk #(
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          note_valid,
  input logic [PW-1:0] note_prio,
  input logic          cur_wr,
  input logic [PW-1:0] cur_wdata,
  input logic          ack,
  input logic [PW-1:0] ack_prio,
  input logic          irq,
  input logic [PW-1:0] pend_buf,
  input logic [PW-1:0] pend_prio,
  input logic [PW-1:0] cur_prio,
  input logic [PW-1:0] status
);
  // R1
  reset_state_chk: assert property (@(posedge clk) !rst_n |=>
    (pend_buf == 0 && cur_prio == 0 && status == 0 && !irq));
  // R4
  empty_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_buf == 0) == (pend_prio == 8'hFF));
  // R4
  top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_buf != 0 |-> (pend_buf[7 - pend_prio[2:0]] && pend_prio < 8
      && (pend_buf >> (8 - pend_prio)) == 0));
  // R2
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> (pend_buf & $past(pend_buf)) == $past(pend_buf));
  // R5
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_wr && cur_wdata > 7 && !ack) |=> $stable(cur_prio));
  // R6
  flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == status[7] && status[6:0] == 0);
  // R8
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !note_valid) |=> (!irq && cur_prio == $past(ack_prio)));
  // R8
  ack_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> ack_prio == pend_prio);
  // R3
  discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (note_valid && note_prio == 8'hFF && !cur_wr && !ack) |=>
      ($stable(pend_buf) && $stable(irq)));
endmodule

bind prio_presenter prio_presenter_chk #(.PW(PW)) chk_i (.*);

// File: tb/prio_presenter_test.sv
module prio_presenter_test;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic note_valid = 0, cur_wr = 0, ack = 0;
  logic [7:0] note_prio = 0, cur_wdata = 0;
  logic [7:0] ack_prio, pend_buf, pend_prio, cur_prio, status;
  logic irq;
  int vectors = 0, errors = 0;
  logic [7:0] m_buf, m_cur;
  logic m_eo;

  prio_presenter uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] clz8(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) if (b[i]) return 8'(7 - i);
    return 8'hFF;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    chk(req, "pend_buf", pend_buf, m_buf);
    chk("R4", "pend_prio", pend_prio, clz8(m_buf));
    chk(req, "cur_prio", cur_prio, m_cur);
    chk(req, "irq", irq, m_eo);
    chk("R6", "status", status, {m_eo, 7'b0});
  endtask

  task automatic step(input logic nv, input logic [7:0] np, input logic cw,
                      input logic [7:0] cd, input logic ak, input string req);
    logic [7:0] pp, nb, nc;
    logic nok, wok;
    note_valid = nv; note_prio = np; cur_wr = cw; cur_wdata = cd; ack = ak;
    #1;
    pp = clz8(m_buf);
    if (ak) chk("R8", "ack_prio", ack_prio, pp);
    nok = nv && np != 8'hFF;
    wok = cw && !ak && cd <= 7;
    nb = m_buf;
    if (ak && pp != 8'hFF) nb[7 - pp[2:0]] = 1'b0;
    if (nok && np <= 7) nb[7 - np[2:0]] = 1'b1;
    nc = ak ? pp : (wok ? cd : m_cur);
    if ((nok || wok) && clz8(nb) < nc) m_eo = 1;
    else if (ak) m_eo = 0;
    m_buf = nb; m_cur = nc;
    @(negedge clk);
    compare_all(req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    m_buf = 0; m_cur = 0; m_eo = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare_all("R1");
    // R5: reject above max, accept 7
    step(0, 0, 1, 8'd9, 0, "R5");
    step(0, 0, 1, 8'd7, 0, "R5");
    // R2: priority 3 sets bit 4, raises irq (R6)
    step(1, 8'd3, 0, 0, 0, "R2");
    step(1, 8'd6, 0, 0, 0, "R2");
    // R3: out-of-range and discarded
    step(1, 8'd20, 0, 0, 0, "R3");
    step(1, 8'hFF, 0, 0, 0, "R3");
    // R8: ack returns 3, clears bit, drops irq, ignores write
    step(0, 0, 1, 8'd1, 1, "R8");
    // R7: simultaneous note 2 and write 2 -> no irq; then write 4 raises
    step(1, 8'd2, 1, 8'd2, 0, "R7");
    step(0, 0, 1, 8'd4, 0, "R7");
    // R8: ack with more favored note in same cycle re-raises
    step(1, 8'd0, 0, 0, 1, "R8");
    step(0, 0, 0, 0, 1, "R8");
    // R8: drain to empty, cppr becomes 0xFF
    repeat (4) step(0, 0, 0, 0, 1, "R8");
    step(1, 8'd7, 0, 0, 0, "R6");
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] np;
      np = ($urandom % 10 == 0) ? 8'($urandom) : 8'($urandom % 8);
      step(($urandom % 3) == 0, np, ($urandom % 5) == 0,
           8'($urandom % 10), ($urandom % 6) == 0, "R7");
    end
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    m_buf = 0; m_cur = 0; m_eo = 0;
    compare_all("R1");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule